// File: doc/BRIEF.md
# Gated Power-of-Two Reference Clock Divider

This block produces one or more divided clocks from a single reference clock. Each channel divides the reference by 1, 2, 4, 8, 16, 32 or 64, and software picks the ratio through a 3-bit code. Software starts and stops each output with an enable bit. Both the code and the enable sit in a small register window per channel, reached through a simple select/write/address/data port that runs on its own bus clock.

The enable bit crosses into the reference domain through a two-flop synchroniser. A per-channel state machine then starts or stops the output. The output only ever starts from low and only ever stops after a full high phase, so it never shows a runt pulse. At ratio 1 the reference itself is passed through a gate that can only open or close while the reference is low. At higher ratios a counter toggles a flop, which gives a 50% duty cycle.

The channel state machine has three states. ST_IDLE holds the output low. The transition start (ST_IDLE to ST_RUN, taken when the synchronised enable is high) captures the ratio code. ST_RUN divides. The transition stop_fast (ST_RUN to ST_IDLE, taken at ratio 1 when the enable is low) leaves directly, because the gate has already closed. The transition stop_drain (ST_RUN to ST_DRAIN, taken at ratios 2 and up when the enable is low) finishes the current high phase first. In ST_DRAIN, the transition drained (ST_DRAIN to ST_IDLE) is taken once the divided clock is low, or at the count that ends the high phase.

Top module: `p2div_top`

## Requirements
- R1: After reset, every code field and enable bit reads 0 and every output is low.
- R2: The divide code is a 3-bit field at bits [2:0] of window offset 0x43. A read of that offset returns the stored code with bits [7:3] as zero.
- R3: The enable is bit 7 of window offset 0x46. Writes to bits [6:0] of that offset, and writes to any other offset, change neither the enable nor the code. A read of offset 0x46 returns the enable in bit 7 and zero elsewhere.
- R4: Codes 0 and 1 both select ratio 1. Code n, for n from 2 to 7, selects ratio 2^(n-1), so code 2 halves the reference and code 7 divides it by 64.
- R5: At any ratio of 2 or more, each high phase and each low phase of the output lasts ratio/2 reference cycles.
- R6: At ratio 1, while the channel is enabled, the output is high when the reference is high and low when the reference is low.
- R7: The first rising edge of the output comes no later than 2 + 3×ratio reference cycles after the bus edge that sets the enable.
- R8: No later than 3×ratio reference cycles after the bus edge that clears the enable, the output is low and stays low.
- R9: Every high phase of the output has full length, including the last one before a stop. The output never stops in the middle of a high phase.
- R10: A code write while the channel runs is stored and reads back at once. The running ratio does not change until the next start.
- R11: Address bits above bit 7 select the channel window, three windows by default, and the channels are independent. Reads of a window with no channel return zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Register port clock |
| bus_rst_n | input | 1 | Register domain asynchronous reset, active low |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 10 | Window number in the upper bits, byte offset in bits [7:0] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid on the bus edge after the read request |
| ref_clk | input | 1 | Reference clock being divided |
| ref_rst_n | input | 1 | Reference domain asynchronous reset, active low |
| clk_out | output | 3 | One gated divided clock per channel |

## Verification
The test bench runs the bus clock and the reference clock from the same source, so every latency can be counted in reference cycles from the bus edge that stores a write. Read data is taken 1 ns after the edge that follows the request.

The output is sampled a quarter period after each reference rising edge. At ratio 1 it is also sampled a quarter period after each falling edge, which covers the pass-through phase. A start is expected to give its first high sample at or before 2 + 3×ratio samples after the write. A stop is expected to give only low samples from sample 3×ratio onward.

A free-running monitor measures every high run on every channel against the ratio the bench last started. Because of this, the drained final pulse of each stop is checked as well as the steady pulses.

// File: rtl/p2div_pkg.sv
package p2div_pkg;

    // Byte offsets inside one channel window
    localparam int unsigned WIN_W = 8;
    localparam logic [WIN_W-1:0] OFS_CODE   = 8'h43;
    localparam logic [WIN_W-1:0] OFS_ENABLE = 8'h46;
    localparam int unsigned EN_BIT = 7;

    // Reference-domain channel sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } div_state_e;

endpackage

// File: rtl/p2div_regs.sv
module p2div_regs
    import p2div_pkg::*;
#(
    parameter int unsigned CODE_W = 3,
    parameter int unsigned DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [WIN_W-1:0]    offset,
    input  logic [DATA_W-1:0]   wdata,
    output logic [CODE_W-1:0]   code_q,
    output logic                en_q,
    output logic [DATA_W-1:0]   rd_data
);

    logic hit_code;
    logic hit_en;
    logic unused_wdata_bits;

    assign hit_code = (offset == OFS_CODE);
    assign hit_en   = (offset == OFS_ENABLE);
    assign unused_wdata_bits = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            en_q   <= 1'b0;
        end else if (wr_en) begin
            if (hit_code) begin
                code_q <= wdata[CODE_W-1:0];
            end
            if (hit_en) begin
                en_q <= wdata[EN_BIT];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_en && hit_code) begin
            rd_data[CODE_W-1:0] = code_q;
        end else if (rd_en && hit_en) begin
            rd_data[EN_BIT] = en_q;
        end
    end

    // R3: the enable follows bit 7 of a write to its offset
    assert_en_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_en) |=> (en_q == $past(wdata[EN_BIT])));

    // R2: the code follows the low bits of a write to its offset
    assert_code_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_code) |=> (code_q == $past(wdata[CODE_W-1:0])));

    // R3: writes elsewhere leave both fields alone
    assert_other_ofs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_code && !hit_en) |=> ($stable(en_q) && $stable(code_q)));

endmodule

// File: rtl/p2div_sync.sv
module p2div_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/p2div_core.sv
module p2div_core
    import p2div_pkg::*;
#(
    parameter int unsigned CODE_W = 3
) (
    input  logic              ref_clk,
    input  logic              ref_rst_n,
    input  logic              en_s,
    input  logic [CODE_W-1:0] code_in,
    output logic              clk_out
);

    // Largest half period is 2^(2^CODE_W - 3) cycles
    localparam int unsigned CNT_W = (1 << CODE_W) - 3;

    div_state_e state_q, state_nx;
    logic [CODE_W-1:0] act_code_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W:0]    half;
    logic [CNT_W-1:0]  half_m1;
    logic              div_q;
    logic              gate_q;
    logic              mode1;
    logic              tick;

    assign mode1 = (act_code_q <= CODE_W'(1));

    always_comb begin
        if (mode1) begin
            half = (CNT_W+1)'(1);
        end else begin
            half = (CNT_W+1)'(1) << (act_code_q - CODE_W'(2));
        end
        half_m1 = CNT_W'(half - (CNT_W+1)'(1));
    end

    assign tick = (cnt_q == half_m1);

    // State register
    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_s) begin
                    state_nx = ST_RUN;                 // start
                end
            end
            ST_RUN: begin
                if (!en_s) begin
                    state_nx = mode1 ? ST_IDLE         // stop_fast
                                     : ST_DRAIN;       // stop_drain
                end
            end
            ST_DRAIN: begin
                if (!div_q || tick) begin
                    state_nx = ST_IDLE;                // drained
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Datapath outputs per state
    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            act_code_q <= '0;
            cnt_q      <= '0;
            div_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    div_q <= 1'b0;
                    if (en_s) begin
                        act_code_q <= code_in;
                    end
                end
                ST_RUN: begin
                    if (!mode1) begin
                        if (tick) begin
                            cnt_q <= '0;
                            div_q <= ~div_q;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_DRAIN: begin
                    if (tick) begin
                        cnt_q <= '0;
                        div_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    cnt_q <= '0;
                    div_q <= 1'b0;
                end
            endcase
        end
    end

    // Ratio-1 gate: only changes while the reference is low
    always_ff @(negedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= (state_q == ST_RUN) && mode1 && en_s;
        end
    end

    assign clk_out = mode1 ? (ref_clk & gate_q) : div_q;

    // Checker: length of the current high phase of the divided flop
    logic [CNT_W:0] hi_len_q;
    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            hi_len_q <= '0;
        end else if (div_q) begin
            hi_len_q <= hi_len_q + (CNT_W+1)'(1);
        end else begin
            hi_len_q <= '0;
        end
    end

    // R9: each high phase, including the drained one, is full length
    assert_full_high_R9: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $fell(div_q) |-> (hi_len_q == half));

    // R10: the captured ratio is frozen outside ST_IDLE
    assert_code_frozen_R10: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (state_q != ST_IDLE) |=> $stable(act_code_q));

    // R1: the idle state keeps both output sources low
    assert_idle_quiet_R1: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (state_q == ST_IDLE) |-> (!div_q && !gate_q));

    // R6: the pass-through gate is open only at ratio 1
    assert_gate_mode_R6: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        gate_q |-> mode1);

endmodule

// File: rtl/p2div_top.sv
module p2div_top
    import p2div_pkg::*;
#(
    parameter int unsigned NUM_CH      = 3,
    parameter int unsigned CODE_W      = 3,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned ADDR_W  = WIN_W + CH_BITS
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_clk,
    input  logic              ref_rst_n,
    output logic [NUM_CH-1:0] clk_out
);

    logic [CH_BITS-1:0] win_idx;
    logic [WIN_W-1:0]   offset;
    logic [DATA_W-1:0]  ch_rd [NUM_CH];
    logic [DATA_W-1:0]  rd_mux;

    assign win_idx = bus_addr[ADDR_W-1:WIN_W];
    assign offset  = bus_addr[WIN_W-1:0];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic              hit;
        logic [CODE_W-1:0] code_q;
        logic              en_q;
        logic              en_s;

        assign hit = bus_sel && (win_idx == CH_BITS'(g));

        p2div_regs #(
            .CODE_W (CODE_W),
            .DATA_W (DATA_W)
        ) u_regs (
            .clk     (bus_clk),
            .rst_n   (bus_rst_n),
            .wr_en   (hit && bus_wr),
            .rd_en   (hit && !bus_wr),
            .offset  (offset),
            .wdata   (bus_wdata),
            .code_q  (code_q),
            .en_q    (en_q),
            .rd_data (ch_rd[g])
        );

        p2div_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk   (ref_clk),
            .rst_n (ref_rst_n),
            .d     (en_q),
            .q     (en_s)
        );

        p2div_core #(
            .CODE_W (CODE_W)
        ) u_core (
            .ref_clk   (ref_clk),
            .ref_rst_n (ref_rst_n),
            .en_s      (en_s),
            .code_in   (code_q),
            .clk_out   (clk_out[g])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            rd_mux = rd_mux | ch_rd[i];
        end
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_mux;
        end
    end

    // R2: code reads never show bits above the field
    assert_code_read_clean_R2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_sel && !bus_wr && offset == OFS_CODE) |=> (bus_rdata[DATA_W-1:CODE_W] == '0));

    // R11: windows without a channel read as zero
    assert_empty_window_R11: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (bus_sel && !bus_wr && (int'(win_idx) >= NUM_CH)) |=> (bus_rdata == '0));

endmodule

// File: tb/p2div_top_tb.sv
`timescale 1ns/1ps
module p2div_top_tb;

    localparam int CLK_PERIOD = 20;
    localparam int Q = CLK_PERIOD / 4;
    localparam int NCH = 3;
    localparam logic [7:0] A_CODE = 8'h43;
    localparam logic [7:0] A_EN   = 8'h46;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [9:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [NCH-1:0] clk_out;

    int n_checks = 0;
    int n_fail = 0;
    int cur_div [NCH];
    int hr [NCH];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    p2div_top u_dut (
        .bus_clk   (clk),
        .bus_rst_n (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ref_clk   (clk),
        .ref_rst_n (rst_n),
        .clk_out   (clk_out)
    );

    function automatic int exp_ratio(int code);
        return (code <= 1) ? 1 : (1 << (code - 1));
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // R9 monitor: every completed high run at ratio >= 2 has ratio/2 samples
    always @(posedge clk) begin
        #(Q);
        for (int c = 0; c < NCH; c++) begin
            if (clk_out[c]) begin
                hr[c]++;
            end else begin
                if (hr[c] > 0 && cur_div[c] >= 2) begin
                    check(hr[c] == cur_div[c] / 2, "R9 high run", hr[c], cur_div[c] / 2);
                end
                hr[c] = 0;
            end
        end
    end

    task automatic bus_write(int ch, logic [7:0] ofs, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = 10'((ch << 8) | int'(ofs)); bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(int ch, logic [7:0] ofs, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0;
        bus_addr = 10'((ch << 8) | int'(ofs));
        @(posedge clk);
        #1 bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic phases_from_high(int ch, output int h, output int l);
        h = 1; l = 0;
        for (int j = 0; j < 200; j++) begin
            @(posedge clk); #(Q);
            if (clk_out[ch]) h++; else break;
        end
        l = 1;
        for (int j = 0; j < 200; j++) begin
            @(posedge clk); #(Q);
            if (!clk_out[ch]) l++; else break;
        end
    endtask

    task automatic start_and_measure(int ch, int code);
        int dv = exp_ratio(code);
        int lim = 2 + 3 * dv;
        int first = -1;
        int h, l;
        cur_div[ch] = dv;
        bus_write(ch, A_EN, 8'h80);
        for (int i = 1; i <= lim + 2 && first < 0; i++) begin
            @(posedge clk); #(Q);
            if (clk_out[ch]) first = i;
        end
        check(first > 0 && first <= lim, "R7 start latency", first, lim);
        if (dv == 1) begin
            for (int j = 0; j < 4; j++) begin
                @(negedge clk); #(Q);
                check(clk_out[ch] == 1'b0, "R6 low half", int'(clk_out[ch]), 0);
                @(posedge clk); #(Q);
                check(clk_out[ch] == 1'b1, "R6 high half", int'(clk_out[ch]), 1);
            end
        end else begin
            phases_from_high(ch, h, l);
            check(h == dv / 2, "R4 R5 high phase", h, dv / 2);
            check(l == dv / 2, "R4 R5 low phase", l, dv / 2);
        end
    endtask

    task automatic stop_and_check(int ch);
        int dv = cur_div[ch];
        int bad = 0;
        bus_write(ch, A_EN, 8'h00);
        for (int i = 1; i <= 4 * dv + 4; i++) begin
            @(posedge clk); #(Q);
            if (i >= 3 * dv && clk_out[ch]) bad++;
        end
        check(bad == 0, "R8 stop latency", bad, 0);
    endtask

    task automatic quiet_check(int ch, string req);
        int hits = 0;
        for (int i = 0; i < 12; i++) begin
            @(posedge clk); #(Q);
            if (clk_out[ch]) hits++;
        end
        check(hits == 0, req, hits, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int h, l;
        void'($urandom(32'd20251));
        for (int c = 0; c < NCH; c++) begin cur_div[c] = 0; hr[c] = 0; end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int c = 0; c < NCH; c++) begin
            bus_read(c, A_CODE, d);
            check(d == 8'h00, "R1 code after reset", int'(d), 0);
            bus_read(c, A_EN, d);
            check(d == 8'h00, "R1 enable after reset", int'(d), 0);
        end
        quiet_check(0, "R1 output low after reset");

        // R2 field masking
        bus_write(0, A_CODE, 8'hFD);
        bus_read(0, A_CODE, d);
        check(d == 8'h05, "R2 code readback", int'(d), 5);

        // R3 ignored bits and offsets
        bus_write(1, A_EN, 8'h7F);
        bus_read(1, A_EN, d);
        check(d == 8'h00, "R3 low bits ignored", int'(d), 0);
        quiet_check(1, "R3 output stays low");
        bus_write(1, 8'h44, 8'hFF);
        bus_read(1, A_CODE, d);
        check(d == 8'h00, "R3 other offset code", int'(d), 0);
        bus_read(1, A_EN, d);
        check(d == 8'h00, "R3 other offset enable", int'(d), 0);
        bus_write(1, A_EN, 8'hFF);
        bus_read(1, A_EN, d);
        check(d == 8'h80, "R3 enable readback", int'(d), 128);
        cur_div[1] = 1;
        stop_and_check(1);

        // R4 codes 0 and 1 both pass through, code 7 is the deepest
        bus_write(0, A_CODE, 8'h00);
        start_and_measure(0, 0);
        stop_and_check(0);
        bus_write(0, A_CODE, 8'h01);
        start_and_measure(0, 1);
        stop_and_check(0);
        bus_write(2, A_CODE, 8'h07);
        start_and_measure(2, 7);
        stop_and_check(2);

        // R10 code change while running
        bus_write(1, A_CODE, 8'h02);
        start_and_measure(1, 2);
        bus_write(1, A_CODE, 8'h04);
        bus_read(1, A_CODE, d);
        check(d == 8'h04, "R10 stored while running", int'(d), 4);
        for (int j = 0; j < 20; j++) begin
            @(posedge clk); #(Q);
            if (clk_out[1]) break;
        end
        phases_from_high(1, h, l);
        check(h == 1 && l == 1, "R10 old ratio kept", h + l, 2);
        stop_and_check(1);
        start_and_measure(1, 4);
        stop_and_check(1);

        // R11 independence and empty window
        bus_write(0, A_CODE, 8'h03);
        cur_div[0] = exp_ratio(3);
        bus_write(0, A_EN, 8'h80);
        bus_write(2, A_CODE, 8'h02);
        start_and_measure(2, 2);
        quiet_check(1, "R11 idle channel unaffected");
        stop_and_check(2);
        stop_and_check(0);
        bus_write(3, A_EN, 8'h80);
        bus_read(3, A_EN, d);
        check(d == 8'h00, "R11 empty window reads zero", int'(d), 0);
        for (int c = 0; c < NCH; c++) quiet_check(c, "R11 empty window write ignored");

        // Random sweep
        for (int it = 0; it < 14; it++) begin
            int ch = int'($urandom % NCH);
            int code = int'($urandom % 8);
            bus_write(ch, A_CODE, 8'(code) | 8'(($urandom % 32) << 3));
            bus_read(ch, A_CODE, d);
            check(int'(d) == code, "R2 random code readback", int'(d), code);
            start_and_measure(ch, code);
            stop_and_check(ch);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule